// File: doc/BRIEF.md
# Differential 8-PSK Symbol Demapper

This block turns a stream of complex baseband samples, one per symbol and taken at the centre of each symbol slot, back into the bit stream that a differential 8-PSK transmitter encoded. Each sample is placed into one of eight phase sectors using only its direction. The sector index of the previous sample is subtracted modulo eight, and the resulting phase step is turned back into a three-bit symbol by undoing the Gray mapping. The three bits then leave on a serial output in the order the transmitter took them from its own input, so the output can be compared bit for bit with the transmitted data.

A burst begins with a one-cycle `burst_start` pulse. The next sample accepted after that pulse only sets the phase reference. Each later sample yields one symbol. Samples are offered with `in_valid` and taken only while `in_ready` is high. This lets the three output bits of a symbol drain one per cycle, and a new sample may be taken on the same cycle the last bit of the previous symbol leaves.

Carrier recovery, timing recovery, pulse-shape filtering and error correction are done elsewhere.

Top module: `d8psk_demap`

## Requirements
- R1: After reset, `bit_valid` is low and `in_ready` is high, and the block waits for a phase reference.
- R2: A sample whose angle lies within pi/8 of k*pi/4 (k = 0..7, angle measured counter-clockwise from the positive I axis) is given sector k. The decision depends only on the signs of I and Q and on the ratio |Q|/|I| compared against tan(pi/8), so it does not change with the sample magnitude. The most negative code on one axis, with zero on the other, maps to the sector on that axis.
- R3: For every sample after the reference, the phase step is (current sector − previous sector) mod 8.
- R4: A phase step d is decoded to a symbol by the inverse Gray table: d=0→0, d=1→1, d=2→3, d=3→2, d=4→7, d=5→6, d=6→4, d=7→5.
- R5: The symbol's bits are presented on `bit_data`, with `bit_valid` high, on the three cycles after the cycle in which the sample is accepted. Bit 0 (LSB) comes first and bit 2 (MSB) comes last.
- R6: The first sample accepted after `burst_start` (or after reset) produces no output bits and only loads the reference. If `burst_start` and an accepted sample share a cycle, that sample is the reference.
- R7: `in_ready` is low while two or three bits of a symbol are still to be emitted. A sample offered while `in_ready` is low is ignored: it neither changes the reference nor produces bits.
- R8: When samples are offered as soon as `in_ready` allows, consecutive symbols come out with no idle cycle between them, at three cycles per symbol.
- R9: The reference follows every accepted sample, so each symbol reflects only the step from the sample directly before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | One-cycle pulse; the next accepted sample becomes the phase reference |
| in_valid | input | 1 | A sample is offered on `in_i`/`in_q` |
| in_ready | output | 1 | The block will take the offered sample this cycle |
| in_i | input | SAMPLE_W | In-phase sample, two's complement |
| in_q | input | SAMPLE_W | Quadrature sample, two's complement |
| bit_valid | output | 1 | `bit_data` holds a decoded bit |
| bit_data | output | 1 | Decoded bit, LSB of each symbol first |

## Verification
A sample is accepted at a rising edge, and the sector decision, the subtraction and the inverse Gray lookup all settle within that same cycle. The first decoded bit is therefore valid one cycle after acceptance, and the second and third bits follow on the next two cycles. `in_ready` falls for two cycles and rises again while the last bit is showing. The bench drives inputs and samples outputs on falling edges. The timing test checks `bit_valid`, `bit_data` and `in_ready` on exactly the first, second, third and fourth falling edges after acceptance. The other tests collect every valid bit, together with its cycle number, and compare the collected stream with one predicted from the sector sequence once the output has gone idle.

// File: rtl/d8_pkg.sv
package d8_pkg;
   localparam int SECTORS  = 8;
   localparam int SYM_BITS = 3;
   typedef logic [SYM_BITS-1:0] sector_t;
   typedef logic [SYM_BITS-1:0] symbol_t;
endpackage

// File: rtl/d8_sector.sv
module d8_sector
   import d8_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int TAN_NUM   = 106,
   parameter int TAN_SHIFT = 8
) (
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   output sector_t             sector
);
   localparam int AW = SAMPLE_W + 1;
   localparam int PW = AW + TAN_SHIFT + 1;

   logic signed [AW-1:0] i_ext, q_ext;
   logic [AW-1:0]        i_mag, q_mag;
   logic [PW-1:0]        i_shl, q_shl, i_tan, q_tan;
   logic                 i_neg, q_neg, near_horiz, near_vert;

   always_comb begin
      i_ext = {in_i[SAMPLE_W-1], in_i};
      q_ext = {in_q[SAMPLE_W-1], in_q};
      i_neg = in_i[SAMPLE_W-1];
      q_neg = in_q[SAMPLE_W-1];
      i_mag = i_neg ? AW'(-i_ext) : AW'(i_ext);
      q_mag = q_neg ? AW'(-q_ext) : AW'(q_ext);
      i_shl = PW'(i_mag) << TAN_SHIFT;
      q_shl = PW'(q_mag) << TAN_SHIFT;
      i_tan = PW'(i_mag) * PW'(TAN_NUM);
      q_tan = PW'(q_mag) * PW'(TAN_NUM);
      near_horiz = (q_shl <= i_tan);
      near_vert  = (i_shl <= q_tan);
   end

   always_comb begin
      if (near_horiz)     sector = i_neg ? 3'd4 : 3'd0;
      else if (near_vert) sector = q_neg ? 3'd6 : 3'd2;
      else begin
         case ({i_neg, q_neg})
            2'b00:   sector = 3'd1;
            2'b10:   sector = 3'd3;
            2'b11:   sector = 3'd5;
            default: sector = 3'd7;
         endcase
      end
   end

   always_comb begin
      if (in_i == '0 && !q_neg && in_q != '0)
         AST_AXIS_NORTH: assert (sector == 3'd2); // R2
      if (in_q == '0 && i_neg)
         AST_AXIS_WEST: assert (sector == 3'd4); // R2
      if (sector == 3'd1)
         AST_DIAG_QUADRANT: assert (!i_neg && !q_neg); // R2
   end
endmodule

// File: rtl/d8_decode.sv
module d8_decode
   import d8_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  logic    ref_only,
   input  sector_t sector,
   output symbol_t sym
);
   sector_t prev_q;
   sector_t step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    prev_q <= '0;
      else if (load) prev_q <= sector;
   end

   assign step = sector - prev_q;

   for (genvar b = 0; b < SYM_BITS; b++) begin : g_ungray
      assign sym[b] = ^step[SYM_BITS-1:b];
   end

   AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ref_only && sector == prev_q) |-> (sym == '0)); // R4
   AST_HALF_TURN: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ref_only && step == 3'd4) |-> (sym == 3'd7)); // R4
endmodule

// File: rtl/d8_serial.sv
module d8_serial
   import d8_pkg::*;
#(
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  symbol_t sym,
   output logic    ready,
   output logic    bit_valid,
   output logic    bit_data
);
   localparam int CW = $clog2(SYM_BITS + 1);

   logic [CW-1:0] cnt_q;
   symbol_t       sh_q, sh_next;

   if (LSB_FIRST) begin : g_lsb
      assign bit_data = sh_q[0];
      assign sh_next  = {1'b0, sh_q[SYM_BITS-1:1]};
   end else begin : g_msb
      assign bit_data = sh_q[SYM_BITS-1];
      assign sh_next  = {sh_q[SYM_BITS-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (load) begin
         cnt_q <= CW'(SYM_BITS);
         sh_q  <= sym;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
         sh_q  <= sh_next;
      end
   end

   assign bit_valid = (cnt_q != '0);
   assign ready     = (cnt_q <= CW'(1));

   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bit_valid) |=> bit_valid); // R5
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !ready) |=> bit_valid); // R7
endmodule

// File: rtl/d8psk_demap.sv
module d8psk_demap
   import d8_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int TAN_NUM   = 106,
   parameter int TAN_SHIFT = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                burst_start,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   output logic                bit_valid,
   output logic                bit_data
);
   if (SAMPLE_W < 4 || SAMPLE_W > 24) begin : g_bad_width
      $error("d8psk_demap: SAMPLE_W out of range");
   end
   if (TAN_SHIFT < 4 || TAN_NUM <= 0 || TAN_NUM >= (1 << TAN_SHIFT)) begin : g_bad_tan
      $error("d8psk_demap: tangent scaling out of range");
   end

   logic    armed_q, armed, accept, data_load;
   sector_t sector;
   symbol_t sym;

   assign armed     = armed_q | burst_start;
   assign accept    = in_valid & in_ready;
   assign data_load = accept & ~armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           armed_q <= 1'b1;
      else if (accept)      armed_q <= 1'b0;
      else if (burst_start) armed_q <= 1'b1;
   end

   d8_sector #(
      .SAMPLE_W (SAMPLE_W),
      .TAN_NUM  (TAN_NUM),
      .TAN_SHIFT(TAN_SHIFT)
   ) i_sector (
      .in_i  (in_i),
      .in_q  (in_q),
      .sector(sector)
   );

   d8_decode i_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .ref_only(armed),
      .sector  (sector),
      .sym     (sym)
   );

   d8_serial #(
      .LSB_FIRST(LSB_FIRST)
   ) i_serial (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (data_load),
      .sym      (sym),
      .ready    (in_ready),
      .bit_valid(bit_valid),
      .bit_data (bit_data)
   );

   AST_REF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && armed) |=> !bit_valid); // R6
   AST_DATA_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !armed) |=> bit_valid); // R5
   AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |-> in_ready); // R1
endmodule

// File: tb/test_d8psk_demap.sv
`timescale 1ns/1ps
module test_d8psk_demap;
   localparam int W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic burst_start = 1'b0;
   logic in_valid = 1'b0;
   logic signed [W-1:0] in_i = '0;
   logic signed [W-1:0] in_q = '0;
   logic in_ready, bit_valid, bit_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit got_q[$];
   int got_c[$];
   bit exp_q[$];
   bit armed_m = 1'b1;
   int prev_m  = 0;

   always #10 clk = ~clk;

   d8psk_demap i_d8psk_demap (
      .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_i(in_i), .in_q(in_q),
      .bit_valid(bit_valid), .bit_data(bit_data)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (bit_valid) begin
         got_q.push_back(bit_data);
         got_c.push_back(cyc);
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int inv_gray(input int d);
      case (d)
         0: return 0; 1: return 1; 2: return 3; 3: return 2;
         4: return 7; 5: return 6; 6: return 4; default: return 5;
      endcase
   endfunction

   task automatic mk(input int k, input int amp, input real off,
                     output logic signed [W-1:0] i, output logic signed [W-1:0] q);
      real a;
      a = (k * 45.0 + off) * 3.14159265358979 / 180.0;
      i = W'($rtoi($floor(amp * $cos(a) + 0.5)));
      q = W'($rtoi($floor(amp * $sin(a) + 0.5)));
   endtask

   task automatic put(input logic signed [W-1:0] i, input logic signed [W-1:0] q);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_i = i; in_q = q;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic model(input int k);
      int s;
      if (armed_m) armed_m = 1'b0;
      else begin
         s = inv_gray((k - prev_m) & 7);
         for (int b = 0; b < 3; b++) exp_q.push_back(s[b]);
      end
      prev_m = k;
   endtask

   task automatic sym(input int k, input int amp, input real off);
      logic signed [W-1:0] i, q;
      mk(k, amp, off, i, q);
      put(i, q);
      model(k);
   endtask

   task automatic start_burst();
      @(negedge clk);
      burst_start = 1'b1;
      @(negedge clk);
      burst_start = 1'b0;
      armed_m = 1'b1;
   endtask

   task automatic drain_clear();
      repeat (6) @(negedge clk);
      got_q.delete(); got_c.delete(); exp_q.delete();
   endtask

   task automatic compare(input string req);
      repeat (6) @(negedge clk);
      check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
      for (int n = 0; n < exp_q.size() && n < got_q.size(); n++)
         check(got_q[n] == exp_q[n], req, got_q[n], exp_q[n]);
      got_q.delete(); got_c.delete(); exp_q.delete();
   endtask

   task automatic t_reset();
      check(bit_valid == 1'b0, "R1 bit_valid", bit_valid, 0);
      check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
   endtask

   task automatic t_all_steps();
      int seq[9] = '{0, 0, 1, 3, 6, 2, 7, 5, 4};
      drain_clear();
      start_burst();
      for (int n = 0; n < 9; n++) sym(seq[n], 1500, 0.0);
      compare("R3 R4 R9 all steps");
      start_burst();
      for (int n = 0; n < 10; n++) sym(n % 8, 1200, 5.0);
      compare("R3 R9 rising chain");
   endtask

   task automatic t_magnitude();
      drain_clear();
      start_burst();
      sym(3, 30, 0.0);
      sym(5, 2040, 15.0);
      sym(2, 60, -15.0);
      sym(7, 1900, 12.0);
      sym(0, 45, -10.0);
      sym(6, 2000, 18.0);
      compare("R2 magnitude independence");
   endtask

   task automatic t_boundary();
      drain_clear();
      start_burst();
      sym(0, 1800, 20.0);
      sym(1, 1800, -20.0);
      sym(2, 1800, 20.0);
      sym(5, 1800, 20.0);
      sym(3, 1800, -20.0);
      sym(7, 1800, 20.0);
      compare("R2 near sector boundaries");
      start_burst();
      put(-12'sd2048, 12'sd0);    model(4);
      put(12'sd0, -12'sd2048);    model(6);
      put(12'sd2047, 12'sd0);     model(0);
      compare("R2 full-scale axes");
   endtask

   task automatic t_timing();
      logic signed [W-1:0] i, q;
      drain_clear();
      start_burst();
      sym(0, 1500, 0.0);
      mk(6, 1500, 0.0, i, q);
      @(negedge clk);
      in_valid = 1'b1; in_i = i; in_q = q;
      @(negedge clk);
      in_valid = 1'b0;
      // phase step 6 -> symbol 4 -> bits 0,0,1
      check(bit_valid == 1'b1 && bit_data == 1'b0, "R5 first bit (LSB)", {bit_valid, bit_data}, 2);
      check(in_ready == 1'b0, "R7 ready low 3 left", in_ready, 0);
      @(negedge clk);
      check(bit_valid == 1'b1 && bit_data == 1'b0, "R5 second bit", {bit_valid, bit_data}, 2);
      check(in_ready == 1'b0, "R7 ready low 2 left", in_ready, 0);
      @(negedge clk);
      check(bit_valid == 1'b1 && bit_data == 1'b1, "R5 third bit (MSB)", {bit_valid, bit_data}, 3);
      check(in_ready == 1'b1, "R8 ready with last bit", in_ready, 1);
      @(negedge clk);
      check(bit_valid == 1'b0, "R5 idle after three bits", bit_valid, 0);
      drain_clear();
   endtask

   task automatic t_burst();
      logic signed [W-1:0] i, q;
      drain_clear();
      start_burst();
      sym(2, 1500, 0.0);
      repeat (3) @(negedge clk);
      check(got_q.size() == 0, "R6 reference silent", got_q.size(), 0);
      mk(5, 1500, 0.0, i, q);
      @(negedge clk);
      burst_start = 1'b1; in_valid = 1'b1; in_i = i; in_q = q;
      @(negedge clk);
      burst_start = 1'b0; in_valid = 1'b0;
      armed_m = 1'b1; model(5);
      repeat (3) @(negedge clk);
      check(got_q.size() == 0, "R6 same-cycle start is reference", got_q.size(), 0);
      sym(6, 1500, 0.0);
      compare("R6 step from new reference");
   endtask

   task automatic t_busy();
      logic signed [W-1:0] i, q;
      drain_clear();
      start_burst();
      sym(1, 1500, 0.0);
      sym(2, 1500, 0.0);
      mk(6, 1500, 0.0, i, q);
      check(in_ready == 1'b0, "R7 busy", in_ready, 0);
      in_valid = 1'b1; in_i = i; in_q = q;
      @(negedge clk);
      in_valid = 1'b0;
      sym(3, 1500, 0.0);
      compare("R7 ignored sample");
   endtask

   task automatic t_stream();
      int seq[6] = '{4, 1, 1, 6, 3, 0};
      drain_clear();
      start_burst();
      for (int n = 0; n < 6; n++) sym(seq[n], 1600, -8.0);
      repeat (6) @(negedge clk);
      check(got_c.size() == 15, "R8 bit count", got_c.size(), 15);
      if (got_c.size() == 15)
         check(got_c[14] - got_c[0] == 14, "R8 no gaps", got_c[14] - got_c[0], 14);
      compare("R8 stream content");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_steps();
      t_magnitude();
      t_boundary();
      t_timing();
      t_burst();
      t_busy();
      t_stream();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule